// File: doc/BRIEF.md
# Latched Status Register Bank with Masked Interrupt

This block collects alarm levels and single-cycle event pulses from a line-interface framer into sticky status bits and gives a host processor a way to see and clear them over a simple parallel bus. Each latched register has a readable snapshot copy. The host writes a mask byte to a status address, and only the bits that carry a one in that mask are refreshed from the latched state. A later read of the same address returns the snapshot and clears just those refreshed bits that showed a one. Any event that arrives after the refresh therefore stays latched until the next pass.

Each latched register has an interrupt mask register beside it. One pending flag per bit drives the active-low interrupt output through that mask. An event pulse sets the flag, and so does an alarm level that changes in either direction. A read that clears the bit also clears the flag. A separate read-only address returns the live synchronizer status with no latching and no mask write.

Top module: `sreg_irq_bank`

## Requirements
- R1: After reset all latched bits, snapshots, pending flags and mask registers are zero, and `int_n` is 1.
- R2: An event-type bit latches to 1 on the clock edge that samples its `event_pls` bit high. It stays 1 until a clearing read (R4).
- R3: A write to a status address (0 = register A, 1 = register B) is a mask. Snapshot bits with a 1 in `wdata` take the latched value held before that edge. Bits with a 0 keep their old snapshot. A read of the address returns the snapshot on `rdata` in the same cycle.
- R4: A read of a status address clears only the latched bits that were refreshed by the most recent mask write to that address and that read as 1. A bit that latched after its refresh survives the read.
- R5: Bits 0 to 3 of register A are alarm-type. The latched bit is 1 whenever `alarm_lvl` is 1, so a read cannot clear it while the alarm persists. `event_pls` has no effect on these bits. All other bits are event-type and ignore `alarm_lvl`.
- R6: Address 2 returns `sync_live` on `rdata` combinationally. A write to it changes nothing.
- R7: Address 3 is the interrupt mask for register A and address 4 is the mask for register B. Both can be written and read back.
- R8: A bit's pending flag sets on an event pulse (event-type) or on any change of its alarm level, rising or falling (alarm-type). `int_n` is 0 in the cycle after the setting edge when that bit's mask is 1, and it stays 1 while all masks are zero. Flat bit index = register*8 + bit.
- R9: The read that clears a bit under R4 also clears its pending flag, even if the alarm is still active. `int_n` returns to 1 only when no other masked flag is pending.
- R10: If an event pulse arrives in the same cycle as a read that would clear that bit, the set wins. The bit and its pending flag both stay 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Register address |
| wdata | input | DATA_W | Write data or refresh mask |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rdata | output | DATA_W | Read data (combinational from addr) |
| alarm_lvl | input | N_REG*DATA_W | Alarm levels, flat index register*8+bit |
| event_pls | input | N_REG*DATA_W | One-cycle event pulses, same indexing |
| sync_live | input | DATA_W | Live synchronizer status |
| int_n | output | 1 | Active-low interrupt |

## Verification
The clearing read and a fresh event pulse on the same bit can land on the same clock edge. The bench provokes this by refreshing a latched bit, then driving that bit's pulse in the very cycle of the read strobe. It judges the result at the ports: the interrupt must stay low, and a second refresh-and-read must again return the bit as 1. A related race, an event that arrives between the refresh write and the read, is checked by showing that the read leaves the bit latched for the next pass.

// File: rtl/sreg_pkg.sv
package sreg_pkg;

    // Kind of register an address decodes to
    typedef enum logic [1:0] {
        ACC_NONE,
        ACC_STAT,
        ACC_LIVE,
        ACC_MASK
    } acc_kind_e;

    // Width of the register index carried with a decoded access
    localparam int unsigned SREG_IDX_W = 4;

    typedef struct packed {
        acc_kind_e               kind;
        logic [SREG_IDX_W-1:0]   idx;
    } acc_sel_t;

endpackage

// File: rtl/sreg_bit_slice.sv
// One latched status register with snapshot, pending flags and mask.
module sreg_bit_slice #(
    parameter int unsigned      W          = 8,
    parameter logic [W-1:0]     ALARM_BITS = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] alarm_lvl,
    input  logic [W-1:0] event_pls,
    input  logic         wr_stat,
    input  logic         rd_stat,
    input  logic         wr_mask,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] latch_o,
    output logic [W-1:0] snap_o,
    output logic [W-1:0] mask_o,
    output logic [W-1:0] irq_src_o
);

    typedef struct packed {
        logic [W-1:0] latch;
        logic [W-1:0] snap;
        logic [W-1:0] armed;
        logic [W-1:0] pend;
        logic [W-1:0] mask;
        logic [W-1:0] alarm_prev;
    } slice_st_t;

    slice_st_t st_d, st_q;

    logic [W-1:0] lvl_a_d, set_lat_d, set_pend_d, clr_d;

    always_comb begin
        st_d = st_q;

        // alarm bits follow level, event bits follow pulses
        lvl_a_d    = alarm_lvl & ALARM_BITS;
        set_lat_d  = lvl_a_d | (event_pls & ~ALARM_BITS);
        set_pend_d = (lvl_a_d ^ st_q.alarm_prev) | (event_pls & ~ALARM_BITS);

        // a read clears what was refreshed and seen as one
        clr_d = rd_stat ? (st_q.armed & st_q.snap) : '0;

        // set has priority over clear
        st_d.latch = (st_q.latch & ~clr_d) | set_lat_d;
        st_d.pend  = (st_q.pend  & ~clr_d) | set_pend_d;

        if (wr_stat) begin
            st_d.snap  = (wdata & st_q.latch) | (~wdata & st_q.snap);
            st_d.armed = wdata;
        end else if (rd_stat) begin
            st_d.armed = '0;
        end

        if (wr_mask) begin
            st_d.mask = wdata;
        end

        st_d.alarm_prev = lvl_a_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign latch_o   = st_q.latch;
    assign snap_o    = st_q.snap;
    assign mask_o    = st_q.mask;
    assign irq_src_o = st_q.pend & st_q.mask;

endmodule

// File: rtl/sreg_bus_decode.sv
// Address decode and read multiplexer for the status bank.
module sreg_bus_decode
    import sreg_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned N_REG  = 2,
    parameter int unsigned ADDR_W = 3
) (
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    wr_en,
    input  logic                    rd_en,
    input  logic [N_REG*DATA_W-1:0] snap_all,
    input  logic [N_REG*DATA_W-1:0] mask_all,
    input  logic [DATA_W-1:0]       sync_live,
    output logic [N_REG-1:0]        wr_stat,
    output logic [N_REG-1:0]        rd_stat,
    output logic [N_REG-1:0]        wr_mask,
    output logic [DATA_W-1:0]       rdata
);

    localparam int unsigned LIVE_ADDR = N_REG;
    localparam int unsigned MASK_BASE = N_REG + 1;
    localparam int unsigned MASK_END  = MASK_BASE + N_REG;

    acc_sel_t sel_d;

    always_comb begin
        sel_d.kind = ACC_NONE;
        sel_d.idx  = '0;
        if (addr < ADDR_W'(N_REG)) begin
            sel_d.kind = ACC_STAT;
            sel_d.idx  = SREG_IDX_W'(addr);
        end else if (addr == ADDR_W'(LIVE_ADDR)) begin
            sel_d.kind = ACC_LIVE;
        end else if ((addr >= ADDR_W'(MASK_BASE)) && (addr < ADDR_W'(MASK_END))) begin
            sel_d.kind = ACC_MASK;
            sel_d.idx  = SREG_IDX_W'(addr - ADDR_W'(MASK_BASE));
        end
    end

    for (genvar r = 0; r < int'(N_REG); r++) begin : g_strobe
        assign wr_stat[r] = wr_en && (sel_d.kind == ACC_STAT) && (sel_d.idx == SREG_IDX_W'(r));
        assign rd_stat[r] = rd_en && (sel_d.kind == ACC_STAT) && (sel_d.idx == SREG_IDX_W'(r));
        assign wr_mask[r] = wr_en && (sel_d.kind == ACC_MASK) && (sel_d.idx == SREG_IDX_W'(r));
    end

    always_comb begin
        rdata = '0;
        unique case (sel_d.kind)
            ACC_LIVE: rdata = sync_live;
            ACC_STAT: begin
                for (int r = 0; r < int'(N_REG); r++) begin
                    if (sel_d.idx == SREG_IDX_W'(r)) rdata = snap_all[r*DATA_W +: DATA_W];
                end
            end
            ACC_MASK: begin
                for (int r = 0; r < int'(N_REG); r++) begin
                    if (sel_d.idx == SREG_IDX_W'(r)) rdata = mask_all[r*DATA_W +: DATA_W];
                end
            end
            default: rdata = '0;
        endcase
    end

endmodule

// File: rtl/sreg_irq_bank.sv
// Bank of latched status registers with masked active-low interrupt.
module sreg_irq_bank #(
    parameter int unsigned                  DATA_W    = 8,
    parameter int unsigned                  N_REG     = 2,
    parameter int unsigned                  ADDR_W    = 3,
    parameter logic [N_REG*DATA_W-1:0]      ALARM_MAP = 16'h000F
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [DATA_W-1:0]       wdata,
    input  logic                    wr_en,
    input  logic                    rd_en,
    output logic [DATA_W-1:0]       rdata,
    input  logic [N_REG*DATA_W-1:0] alarm_lvl,
    input  logic [N_REG*DATA_W-1:0] event_pls,
    input  logic [DATA_W-1:0]       sync_live,
    output logic                    int_n
);

    localparam int unsigned NB = N_REG * DATA_W;

    logic [N_REG-1:0] wr_stat, rd_stat, wr_mask;
    logic [NB-1:0]    latch_all, snap_all, mask_all, irq_src_all;

    sreg_bus_decode #(
        .DATA_W (DATA_W),
        .N_REG  (N_REG),
        .ADDR_W (ADDR_W)
    ) u_dec (
        .addr      (addr),
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .snap_all  (snap_all),
        .mask_all  (mask_all),
        .sync_live (sync_live),
        .wr_stat   (wr_stat),
        .rd_stat   (rd_stat),
        .wr_mask   (wr_mask),
        .rdata     (rdata)
    );

    for (genvar r = 0; r < int'(N_REG); r++) begin : g_reg
        sreg_bit_slice #(
            .W          (DATA_W),
            .ALARM_BITS (ALARM_MAP[r*DATA_W +: DATA_W])
        ) u_slice (
            .clk       (clk),
            .rst_n     (rst_n),
            .alarm_lvl (alarm_lvl[r*DATA_W +: DATA_W]),
            .event_pls (event_pls[r*DATA_W +: DATA_W]),
            .wr_stat   (wr_stat[r]),
            .rd_stat   (rd_stat[r]),
            .wr_mask   (wr_mask[r]),
            .wdata     (wdata),
            .latch_o   (latch_all[r*DATA_W +: DATA_W]),
            .snap_o    (snap_all[r*DATA_W +: DATA_W]),
            .mask_o    (mask_all[r*DATA_W +: DATA_W]),
            .irq_src_o (irq_src_all[r*DATA_W +: DATA_W])
        );
    end

    assign int_n = ~(|irq_src_all);

endmodule

// File: rtl/sreg_irq_checker.sv
// Temporal checks for sreg_irq_bank, attached by bind below.
module sreg_irq_checker #(
    parameter int unsigned                  DATA_W    = 8,
    parameter int unsigned                  N_REG     = 2,
    parameter int unsigned                  ADDR_W    = 3,
    parameter logic [N_REG*DATA_W-1:0]      ALARM_MAP = 16'h000F
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [ADDR_W-1:0]       addr,
    input logic                    wr_en,
    input logic [DATA_W-1:0]       rdata,
    input logic [N_REG*DATA_W-1:0] alarm_lvl,
    input logic [N_REG*DATA_W-1:0] event_pls,
    input logic [DATA_W-1:0]       sync_live,
    input logic                    int_n,
    input logic [N_REG*DATA_W-1:0] latch_all,
    input logic [N_REG*DATA_W-1:0] snap_all,
    input logic [N_REG*DATA_W-1:0] mask_all
);

    localparam logic [N_REG*DATA_W-1:0] EVT_MAP = ~ALARM_MAP;

    // R1: reset leaves everything cleared and the interrupt released
    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> (int_n && (mask_all == '0) && (latch_all == '0) && (snap_all == '0)));

    // R3: snapshots only move on a status write
    p_snap_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && (addr < ADDR_W'(N_REG))) |=> $stable(snap_all));

    // R2 and R10: a pulsed event bit is latched on the next edge, even against a clearing read
    p_event_sticks_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (|(event_pls & EVT_MAP)) |=>
        ((latch_all & $past(event_pls & EVT_MAP)) == $past(event_pls & EVT_MAP)));

    // R5: an active alarm keeps its latched bit set
    p_alarm_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((latch_all & $past(alarm_lvl & ALARM_MAP)) == $past(alarm_lvl & ALARM_MAP)));

    // R6: the live address shows the live input
    p_live_view_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == ADDR_W'(N_REG)) |-> (rdata == sync_live));

    // R8: no enabled bit means no interrupt
    p_masked_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_all == '0) |-> int_n);

    // R8: an enabled event pulls the interrupt low on the next cycle
    p_event_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((|(event_pls & EVT_MAP & mask_all)) && !wr_en) |=> !int_n);

endmodule

bind sreg_irq_bank sreg_irq_checker #(
    .DATA_W    (DATA_W),
    .N_REG     (N_REG),
    .ADDR_W    (ADDR_W),
    .ALARM_MAP (ALARM_MAP)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr      (addr),
    .wr_en     (wr_en),
    .rdata     (rdata),
    .alarm_lvl (alarm_lvl),
    .event_pls (event_pls),
    .sync_live (sync_live),
    .int_n     (int_n),
    .latch_all (latch_all),
    .snap_all  (snap_all),
    .mask_all  (mask_all)
);

// File: tb/sreg_irq_bank_bench.sv
module sreg_irq_bank_bench;

    localparam int CLK_PERIOD = 10;
    localparam int DW = 8;
    localparam int NR = 2;
    localparam int AW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [DW-1:0] rdata;
    logic [NR*DW-1:0] alarm_lvl = '0;
    logic [NR*DW-1:0] event_pls = '0;
    logic [DW-1:0] sync_live = '0;
    logic          int_n;

    sreg_irq_bank u_sreg_irq_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr      (addr),
        .wdata     (wdata),
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .rdata     (rdata),
        .alarm_lvl (alarm_lvl),
        .event_pls (event_pls),
        .sync_live (sync_live),
        .int_n     (int_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        bit            is_int;
        logic [DW-1:0] exp;
        string         tag;
    } exp_item_t;

    exp_item_t exp_q[$];
    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // monitor: compare queued expectations a quarter period after the falling edge
    initial begin
        forever begin
            @(negedge clk);
            #(CLK_PERIOD/4);
            while (exp_q.size() > 0) begin
                exp_item_t it;
                logic [DW-1:0] act;
                it  = exp_q.pop_front();
                act = it.is_int ? {{(DW-1){1'b0}}, int_n} : rdata;
                n_vec++;
                if (act !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s: %s actual=%h expected=%h",
                             it.tag, it.is_int ? "int_n" : "rdata", act, it.exp);
                end
            end
        end
    end

    task automatic idle_step();
        wr_en     = 1'b0;
        rd_en     = 1'b0;
        event_pls = '0;
    endtask

    task automatic cyc();
        @(negedge clk);
        idle_step();
    endtask

    task automatic bus_wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        idle_step();
        addr  = a;
        wdata = d;
        wr_en = 1'b1;
    endtask

    task automatic bus_rd(input logic [AW-1:0] a, input logic [DW-1:0] e, input string tag);
        exp_item_t it;
        @(negedge clk);
        idle_step();
        addr  = a;
        rd_en = 1'b1;
        it.is_int = 1'b0; it.exp = e; it.tag = tag;
        exp_q.push_back(it);
    endtask

    task automatic bus_rd_ev(input logic [AW-1:0] a, input logic [DW-1:0] e,
                             input int idx, input string tag);
        exp_item_t it;
        @(negedge clk);
        idle_step();
        addr  = a;
        rd_en = 1'b1;
        event_pls[idx] = 1'b1;
        it.is_int = 1'b0; it.exp = e; it.tag = tag;
        exp_q.push_back(it);
    endtask

    task automatic chk_int(input logic v, input string tag);
        exp_item_t it;
        @(negedge clk);
        idle_step();
        it.is_int = 1'b1; it.exp = {{(DW-1){1'b0}}, v}; it.tag = tag;
        exp_q.push_back(it);
    endtask

    task automatic pulse_ev(input int idx);
        @(negedge clk);
        idle_step();
        event_pls[idx] = 1'b1;
    endtask

    task automatic set_alarm(input int idx, input logic v);
        @(negedge clk);
        idle_step();
        alarm_lvl[idx] = v;
    endtask

    task automatic set_live(input logic [DW-1:0] v);
        @(negedge clk);
        idle_step();
        sync_live = v;
    endtask

    // watchdog
    initial begin
        #(CLK_PERIOD*20000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk_int(1'b1, "R1");
        bus_rd(3'd0, 8'h00, "R1");
        bus_rd(3'd1, 8'h00, "R1");
        bus_rd(3'd3, 8'h00, "R1");
        bus_rd(3'd4, 8'h00, "R1");

        // R8 masked event stays silent; R3 snapshot untouched without refresh
        pulse_ev(10);
        chk_int(1'b1, "R8");
        bus_rd(3'd1, 8'h00, "R3");
        bus_wr(3'd4, 8'h04);
        chk_int(1'b0, "R8");
        bus_rd(3'd4, 8'h04, "R7");

        // R3 refresh, R9 release, R2 cleared afterwards
        bus_wr(3'd1, 8'h04);
        bus_rd(3'd1, 8'h04, "R3");
        chk_int(1'b1, "R9");
        bus_wr(3'd1, 8'hFF);
        bus_rd(3'd1, 8'h00, "R2");

        // R4 selective clear across two bits
        pulse_ev(8);
        pulse_ev(13);
        bus_wr(3'd1, 8'h01);
        bus_rd(3'd1, 8'h01, "R4");
        bus_wr(3'd1, 8'h20);
        bus_rd(3'd1, 8'h21, "R3");
        bus_wr(3'd1, 8'hFF);
        bus_rd(3'd1, 8'h00, "R4");

        // R4 event between refresh and read survives
        bus_wr(3'd1, 8'h02);
        pulse_ev(9);
        bus_rd(3'd1, 8'h00, "R4");
        bus_wr(3'd1, 8'h02);
        bus_rd(3'd1, 8'h02, "R4");
        bus_wr(3'd1, 8'hFF);
        bus_rd(3'd1, 8'h00, "R2");

        // R10 set wins against a clearing read
        pulse_ev(10);
        bus_wr(3'd1, 8'hFF);
        bus_rd_ev(3'd1, 8'h04, 10, "R10");
        chk_int(1'b0, "R10");
        bus_wr(3'd1, 8'hFF);
        bus_rd(3'd1, 8'h04, "R10");
        chk_int(1'b1, "R9");

        // R5 / R8 / R9 alarm on bit 0 of register A
        bus_wr(3'd3, 8'h01);
        set_alarm(0, 1'b1);
        chk_int(1'b0, "R8");
        bus_wr(3'd0, 8'h01);
        bus_rd(3'd0, 8'h01, "R5");
        chk_int(1'b1, "R9");
        bus_wr(3'd0, 8'h01);
        bus_rd(3'd0, 8'h01, "R5");
        chk_int(1'b1, "R8");
        set_alarm(0, 1'b0);
        chk_int(1'b0, "R8");
        bus_wr(3'd0, 8'h01);
        bus_rd(3'd0, 8'h01, "R9");
        chk_int(1'b1, "R9");
        bus_wr(3'd0, 8'h01);
        bus_rd(3'd0, 8'h00, "R2");

        // R6 live register and write to it ignored; R7 masks intact
        set_live(8'hA5);
        bus_rd(3'd2, 8'hA5, "R6");
        set_live(8'h3C);
        bus_rd(3'd2, 8'h3C, "R6");
        bus_wr(3'd2, 8'hFF);
        bus_rd(3'd2, 8'h3C, "R6");
        bus_rd(3'd0, 8'h00, "R6");
        bus_rd(3'd3, 8'h01, "R7");
        bus_rd(3'd4, 8'h04, "R7");

        // R9 interrupt held by a second source
        bus_wr(3'd3, 8'h11);
        pulse_ev(4);
        pulse_ev(10);
        chk_int(1'b0, "R8");
        bus_wr(3'd0, 8'h10);
        bus_rd(3'd0, 8'h10, "R9");
        chk_int(1'b0, "R9");
        bus_wr(3'd1, 8'h04);
        bus_rd(3'd1, 8'h04, "R9");
        chk_int(1'b1, "R9");

        // R5 pulse input on an alarm-type bit has no effect
        bus_wr(3'd3, 8'h02);
        pulse_ev(1);
        chk_int(1'b1, "R5");
        bus_wr(3'd0, 8'hFF);
        bus_rd(3'd0, 8'h00, "R5");

        cyc();
        cyc();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule